// File: doc/BRIEF.md
# SPI Master Shift Engine

This block is the serial core of an SPI master. Software or a sequencer loads words into a small transmit queue. The engine takes each word and shifts it out on the serial data output, with a clock that it builds from the system clock through a programmable divider. At the same time it samples the serial data input and places each completed word in a receive queue. The data path is the same for every word width up to the maximum. The clock mode, the bit order and an internal loop from the output to the input are all selectable.

The block has two operating states, set by an enable input. While the enable is low, the block is in config mode: the divider, the word width and the mode bits are copied into internal registers, and words may be queued without starting a transfer. While the enable is high, the copied settings are frozen and the engine drains the transmit queue word by word. The busy flag stays high until the last queued word has left the shift register completely. Because of that, it can be used to decide when the chip select may be released. Two separate inputs switch the transmit direction and the receive direction off, each one independently of the other.

Top module: `spi_shift_master`

## Requirements
- R1: Every half period of the serial clock during a word lasts exactly cfgBaud+1 system clock cycles. The serial clock frequency is therefore fclk / (2*(cfgBaud+1)).
- R2: cfgWidthM1 holds the word width minus one. A word of width W produces exactly 2*W serial clock edges and transfers W bits in each direction.
- R3: When cfgPhaseN=1, the input is sampled on the leading edge of each bit and the output changes on the trailing edge. When cfgPhaseN=0, the output changes on the leading edge and the input is sampled on the trailing edge. The first bit is presented before the first edge in both modes.
- R4: During a word the serial clock starts from the cfgPolarity level, so the leading edge moves away from that level. Between words and in config mode the serial clock rests at the cfgIdleHigh level.
- R5: When cfgMsbFirst=1, bit W-1 of the word goes out first. When cfgMsbFirst=0, bit 0 goes out first. Received bits are placed in the matching order.
- R6: When cfgLoopback=1, the receiver samples the transmitted serial output and ignores the miso pin.
- R7: A received word is right-aligned in rxData, and bits W and above read as zero.
- R8: When cfgTxOff=1, mosi stays at 0 while words are still clocked. When cfgRxOff=1, completed words are not stored in the receive queue.
- R9: Width, divider, polarity, idle level, phase, bit order and loopback are taken from the inputs only while cfgEnable=0. Changes made while the block is active have no effect on the words being sent.
- R10: txEmptyIrq pulses for one cycle, one cycle after the last queued word has been moved into the shift register. busy is high at that pulse and stays high until that word's final clock edge.
- R11: A write to a full transmit queue is dropped and pulses txOverflow. A word completed into a full receive queue is dropped and pulses rxOverflow. A read of an empty receive queue pulses rxUnderflow. Each of these pulses lasts one cycle and comes one cycle after its cause.
- R12: After reset, busy, rxValid, sclk and all error and interrupt pulses are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgEnable | input | 1 | 1 = active mode, 0 = config mode |
| cfgWidthM1 | input | 5 | Word width minus one |
| cfgBaud | input | 8 | Divider value for each half period |
| cfgPolarity | input | 1 | Clock level at the start of a word |
| cfgIdleHigh | input | 1 | Clock level between words |
| cfgPhaseN | input | 1 | 1 = sample on leading edge, 0 = sample on trailing edge |
| cfgMsbFirst | input | 1 | 1 = most significant bit first |
| cfgLoopback | input | 1 | Internal loop from mosi to the receiver |
| cfgTxOff | input | 1 | Hold mosi at 0 |
| cfgRxOff | input | 1 | Discard received words |
| txWrite | input | 1 | Push txData into the transmit queue |
| txData | input | 32 | Word to transmit, right-aligned |
| rxRead | input | 1 | Pop the receive queue head |
| rxData | output | 32 | Receive queue head, right-aligned |
| rxValid | output | 1 | Receive queue not empty |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| busy | output | 1 | A word is being shifted |
| txEmptyIrq | output | 1 | Transmit queue drained (pulse) |
| txOverflow | output | 1 | Write to full transmit queue (pulse) |
| rxOverflow | output | 1 | Word lost on full receive queue (pulse) |
| rxUnderflow | output | 1 | Read of empty receive queue (pulse) |

## Verification
The assertions check the following on every cycle: the divider and half-period counters stay inside the latched limits, the latched settings cannot move while the block is active, launch and sample never happen in the same tick, a completed receive word carries no bits above its width, the queue occupancy stays bounded, and busy is high whenever the empty interrupt fires. The bench scenarios are needed for everything that depends on the wire. They cover the order and timing of bits relative to the clock edges in all four clock modes, the edge spacing and the edge count for each width, the loopback path, the switching off of each direction, and the overflow and underflow pulses that follow from a queue sequence.

// File: rtl/spi_eng_pkg.sv
package spi_eng_pkg;
  // Strobes passed from the sequencing control to the shift datapath.
  typedef struct packed {
    logic load;    // take a new word from the transmit queue
    logic launch;  // advance the transmit shift register
    logic sample;  // capture one input bit
    logic finish;  // the word is complete
  } engStrobes_t;

  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_FIN} engState_t;
endpackage

// File: rtl/spi_word_fifo.sv
module spi_word_fifo #(
  parameter int WIDTH = 32,
  parameter int DEPTH = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             push,
  input  logic [WIDTH-1:0] wrData,
  input  logic             pop,
  output logic [WIDTH-1:0] rdData,
  output logic             empty,
  output logic             full,
  output logic             lastOne
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0] wrPtr, rdPtr;
  logic [CW-1:0] count;
  logic doPush, doPop;

  function automatic logic [AW-1:0] nextPtr(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign empty   = (count == '0);
  assign full    = (count == CW'(DEPTH));
  assign lastOne = (count == CW'(1));
  assign doPush  = push && !full;
  assign doPop   = pop && !empty;
  assign rdData  = mem[rdPtr];

  always_ff @(posedge clk) begin
    if (doPush) mem[wrPtr] <= wrData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (doPush) wrPtr <= nextPtr(wrPtr);
      if (doPop)  rdPtr <= nextPtr(rdPtr);
      count <= count + CW'(doPush) - CW'(doPop);
    end
  end

  // R11: occupancy never exceeds the depth
  p_count_bound_r11: assert property (@(posedge clk) disable iff (!rstN)
    count <= CW'(DEPTH));
  // R11: a push into a full queue that is not drained leaves it full
  p_full_drop_r11: assert property (@(posedge clk) disable iff (!rstN)
    (push && full && !pop) |=> full);
endmodule

// File: rtl/spi_shift_ctrl.sv
module spi_shift_ctrl
  import spi_eng_pkg::*;
#(
  parameter int WBITS = 5,
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             enable,
  input  logic             txAvail,
  input  logic [WBITS-1:0] widthM1,
  input  logic [DIV_W-1:0] baud,
  input  logic             polarity,
  input  logic             idleHigh,
  input  logic             phaseN,
  output engStrobes_t      strobes,
  output logic             sclk,
  output logic             busy
);
  engState_t state;
  logic [DIV_W-1:0] divCnt;
  logic [WBITS:0]   halfCnt;
  logic [WBITS:0]   lastHalf;
  logic tick, leading;

  assign lastHalf = {widthM1, 1'b1};
  assign tick     = (state == ST_RUN) && enable && (divCnt == baud);
  assign leading  = !halfCnt[0];

  always_comb begin
    strobes.load   = (state != ST_RUN) && enable && txAvail;
    strobes.sample = tick && (phaseN ? leading : !leading);
    strobes.launch = tick && (phaseN ? (!leading && halfCnt != lastHalf)
                                     : (leading && halfCnt != '0));
    strobes.finish = (state == ST_FIN);
  end

  assign busy = (state != ST_IDLE);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      divCnt  <= '0;
      halfCnt <= '0;
      sclk    <= 1'b0;
    end else begin
      case (state)
        ST_RUN: begin
          if (!enable) begin
            state <= ST_IDLE;
            sclk  <= idleHigh;
          end else if (divCnt == baud) begin
            divCnt <= '0;
            sclk   <= !sclk;
            if (halfCnt == lastHalf) state <= ST_FIN;
            else halfCnt <= halfCnt + 1'b1;
          end else begin
            divCnt <= divCnt + 1'b1;
          end
        end
        default: begin
          if (enable && txAvail) begin
            state   <= ST_RUN;
            divCnt  <= '0;
            halfCnt <= '0;
            sclk    <= polarity;
          end else begin
            state <= ST_IDLE;
            sclk  <= idleHigh;
          end
        end
      endcase
    end
  end

  // R1: divider count stays inside the latched half period
  p_div_bound_r1: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_RUN) |-> (divCnt <= baud));
  // R2: never more than 2*W half periods in a word
  p_half_bound_r2: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_RUN) |-> (halfCnt <= lastHalf));
  // R3: launch and sample never share a tick
  p_edge_excl_r3: assert property (@(posedge clk) disable iff (!rstN)
    !(strobes.launch && strobes.sample));
  // R4: a settled idle engine rests at the idle level
  p_idle_level_r4: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE && $past(state == ST_IDLE) && $stable(idleHigh)) |-> (sclk == idleHigh));
endmodule

// File: rtl/spi_shift_datapath.sv
module spi_shift_datapath
  import spi_eng_pkg::*;
#(
  parameter int MAX_W = 32,
  parameter int WBITS = 5
) (
  input  logic             clk,
  input  logic             rstN,
  input  engStrobes_t      strobes,
  input  logic [WBITS-1:0] widthM1,
  input  logic             msbFirst,
  input  logic             loopback,
  input  logic             txOff,
  input  logic [MAX_W-1:0] txWord,
  input  logic             miso,
  output logic             mosi,
  output logic [MAX_W-1:0] rxWord
);
  logic [MAX_W-1:0] txShift, rxShift, wordMask;
  logic [WBITS-1:0] sampCnt;
  logic inBit;

  assign wordMask = ~({MAX_W{1'b1}} << ({1'b0, widthM1} + 1'b1));
  assign mosi     = txOff ? 1'b0 : (msbFirst ? txShift[widthM1] : txShift[0]);
  assign inBit    = loopback ? mosi : miso;
  assign rxWord   = rxShift;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txShift <= '0;
      rxShift <= '0;
      sampCnt <= '0;
    end else if (strobes.load) begin
      txShift <= txWord & wordMask;
      rxShift <= '0;
      sampCnt <= '0;
    end else begin
      if (strobes.launch) begin
        if (msbFirst) txShift <= txShift << 1;
        else          txShift <= txShift >> 1;
      end
      if (strobes.sample) begin
        if (msbFirst) rxShift <= {rxShift[MAX_W-2:0], inBit};
        else          rxShift[sampCnt] <= inBit;
        sampCnt <= sampCnt + 1'b1;
      end
    end
  end

  // R7: a completed word has nothing above its width
  p_rx_aligned_r7: assert property (@(posedge clk) disable iff (!rstN)
    strobes.finish |-> ((rxWord & ~wordMask) == '0));
endmodule

// File: rtl/spi_shift_master.sv
module spi_shift_master
  import spi_eng_pkg::*;
#(
  parameter int MAX_W    = 32,
  parameter int DIV_W    = 8,
  parameter int TX_DEPTH = 4,
  parameter int RX_DEPTH = 4,
  localparam int WBITS   = $clog2(MAX_W)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cfgEnable,
  input  logic [WBITS-1:0] cfgWidthM1,
  input  logic [DIV_W-1:0] cfgBaud,
  input  logic             cfgPolarity,
  input  logic             cfgIdleHigh,
  input  logic             cfgPhaseN,
  input  logic             cfgMsbFirst,
  input  logic             cfgLoopback,
  input  logic             cfgTxOff,
  input  logic             cfgRxOff,
  input  logic             txWrite,
  input  logic [MAX_W-1:0] txData,
  input  logic             rxRead,
  output logic [MAX_W-1:0] rxData,
  output logic             rxValid,
  output logic             sclk,
  output logic             mosi,
  input  logic             miso,
  output logic             busy,
  output logic             txEmptyIrq,
  output logic             txOverflow,
  output logic             rxOverflow,
  output logic             rxUnderflow
);
  logic [WBITS-1:0] widthQ;
  logic [DIV_W-1:0] baudQ;
  logic polQ, idleQ, phaseQ, msbQ, loopQ;
  engStrobes_t strobes;
  logic [MAX_W-1:0] txHead, rxWord;
  logic txEmpty, txFull, txLast, rxEmpty, rxFull, rxLastUnused, rxPush;

  // Settings are copied only in config mode
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      widthQ <= '0; baudQ <= '0;
      polQ <= 1'b0; idleQ <= 1'b0; phaseQ <= 1'b0; msbQ <= 1'b0; loopQ <= 1'b0;
    end else if (!cfgEnable) begin
      widthQ <= cfgWidthM1; baudQ <= cfgBaud;
      polQ <= cfgPolarity; idleQ <= cfgIdleHigh; phaseQ <= cfgPhaseN;
      msbQ <= cfgMsbFirst; loopQ <= cfgLoopback;
    end
  end

  spi_word_fifo #(.WIDTH(MAX_W), .DEPTH(TX_DEPTH)) i_txFifo (
    .clk, .rstN, .push(txWrite), .wrData(txData), .pop(strobes.load),
    .rdData(txHead), .empty(txEmpty), .full(txFull), .lastOne(txLast));

  assign rxPush = strobes.finish && !cfgRxOff;

  spi_word_fifo #(.WIDTH(MAX_W), .DEPTH(RX_DEPTH)) i_rxFifo (
    .clk, .rstN, .push(rxPush), .wrData(rxWord), .pop(rxRead),
    .rdData(rxData), .empty(rxEmpty), .full(rxFull), .lastOne(rxLastUnused));

  assign rxValid = !rxEmpty;

  spi_shift_ctrl #(.WBITS(WBITS), .DIV_W(DIV_W)) i_ctrl (
    .clk, .rstN, .enable(cfgEnable), .txAvail(!txEmpty), .widthM1(widthQ),
    .baud(baudQ), .polarity(polQ), .idleHigh(idleQ), .phaseN(phaseQ),
    .strobes, .sclk, .busy);

  spi_shift_datapath #(.MAX_W(MAX_W), .WBITS(WBITS)) i_dp (
    .clk, .rstN, .strobes, .widthM1(widthQ), .msbFirst(msbQ), .loopback(loopQ),
    .txOff(cfgTxOff), .txWord(txHead), .miso, .mosi, .rxWord);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txEmptyIrq <= 1'b0; txOverflow <= 1'b0; rxOverflow <= 1'b0; rxUnderflow <= 1'b0;
    end else begin
      txEmptyIrq  <= strobes.load && txLast && !(txWrite && !txFull);
      txOverflow  <= txWrite && txFull;
      rxOverflow  <= rxPush && rxFull;
      rxUnderflow <= rxRead && rxEmpty;
    end
  end

  // R9: latched settings do not move after an active cycle
  p_cfg_frozen_r9: assert property (@(posedge clk) disable iff (!rstN)
    $past(cfgEnable) |-> ($stable(widthQ) && $stable(baudQ) && $stable(phaseQ)));
  // R10: the drain interrupt arrives while the last word is still shifting
  p_irq_busy_r10: assert property (@(posedge clk) disable iff (!rstN)
    txEmptyIrq |-> busy);
endmodule

// File: tb/test_spi_shift_master.sv
`timescale 1ns/1ps
module test_spi_shift_master;
  logic clk = 1'b0, rstN = 1'b0;
  logic cfgEnable = 1'b0, cfgPolarity = 1'b0, cfgIdleHigh = 1'b0, cfgPhaseN = 1'b0;
  logic cfgMsbFirst = 1'b0, cfgLoopback = 1'b0, cfgTxOff = 1'b0, cfgRxOff = 1'b0;
  logic [4:0] cfgWidthM1 = 5'd7;
  logic [7:0] cfgBaud = 8'd0;
  logic txWrite = 1'b0, rxRead = 1'b0, miso = 1'b0;
  logic [31:0] txData = '0;
  logic [31:0] rxData;
  logic rxValid, sclk, mosi, busy, txEmptyIrq, txOverflow, rxOverflow, rxUnderflow;

  int nChecks = 0, nFail = 0;
  // serial slave model state
  bit armed = 0, slMsb = 0, slPhN = 0;
  int slW = 8, edgeNo = 0, sampNo = 0, gapErr = 0;
  real prevT = 0.0, gapExp = 5.0;
  logic [31:0] capWord = '0, slaveWord = '0;
  // pulse monitors
  int irqSeen = 0, irqEdges = 0, txOvf = 0, rxOvf = 0, rxUnf = 0;
  bit irqBusy = 0;

  always #2.5 clk = ~clk;

  spi_shift_master i_spi_shift_master (
    .clk, .rstN, .cfgEnable, .cfgWidthM1, .cfgBaud, .cfgPolarity, .cfgIdleHigh,
    .cfgPhaseN, .cfgMsbFirst, .cfgLoopback, .cfgTxOff, .cfgRxOff, .txWrite, .txData,
    .rxRead, .rxData, .rxValid, .sclk, .mosi, .miso, .busy, .txEmptyIrq,
    .txOverflow, .rxOverflow, .rxUnderflow);

  function automatic int bitPos(int k);
    return slMsb ? (slW - 1 - k) : k;
  endfunction

  function automatic logic [31:0] maskOf(int w);
    return (w >= 32) ? 32'hFFFF_FFFF : ((32'h1 << w) - 1);
  endfunction

  always @(sclk) begin
    if (armed) begin
      edgeNo++;
      if (edgeNo > 1 && (($realtime - prevT) > gapExp + 0.1 || ($realtime - prevT) < gapExp - 0.1))
        gapErr++;
      prevT = $realtime;
      if ((edgeNo % 2 == 1) == slPhN) begin
        if (sampNo < slW) capWord[bitPos(sampNo)] = mosi;
        sampNo++;
        if (sampNo < slW) miso = slaveWord[bitPos(sampNo)];
      end
    end
  end

  always @(negedge clk) begin
    if (txEmptyIrq) begin irqSeen++; irqBusy = busy; irqEdges = edgeNo; end
    if (txOverflow) txOvf++;
    if (rxOverflow) rxOvf++;
    if (rxUnderflow) rxUnf++;
  end

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("  %0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  endtask

  task automatic waitIdle();
    int guard = 0;
    repeat (2) @(negedge clk);
    while (busy && guard < 20000) begin @(negedge clk); guard++; end
    if (guard >= 20000) chk(0, "R10 busy never cleared", 32'(busy), 32'h0);
  endtask

  task automatic runWord(int w, bit cpol, bit phN, bit msb, int baud,
                         logic [31:0] txw, logic [31:0] slw,
                         bit loop, bit txo, bit rxo, bit tamper);
    logic [31:0] expRx;
    @(negedge clk);
    cfgEnable = 0; cfgWidthM1 = 5'(w - 1); cfgBaud = 8'(baud);
    cfgPolarity = cpol; cfgIdleHigh = cpol; cfgPhaseN = phN; cfgMsbFirst = msb;
    cfgLoopback = loop; cfgTxOff = txo; cfgRxOff = rxo;
    repeat (3) @(negedge clk);
    slW = w; slMsb = msb; slPhN = phN; slaveWord = slw; gapExp = 5.0 * (baud + 1);
    edgeNo = 0; sampNo = 0; gapErr = 0; capWord = '0; irqSeen = 0;
    miso = slw[bitPos(0)];
    armed = 1;
    txData = txw; txWrite = 1; cfgEnable = 1;
    if (tamper) begin cfgWidthM1 = 5'd15; cfgBaud = 8'd6; cfgMsbFirst = !msb; end
    @(negedge clk);
    txWrite = 0;
    waitIdle();
    armed = 0;
    chk(gapErr == 0, "R1 edge spacing", 32'(gapErr), 32'h0);
    chk(edgeNo == 2 * w, "R2 edge count", 32'(edgeNo), 32'(2 * w));
    chk(capWord == (txo ? 32'h0 : (txw & maskOf(w))), "R3/R5/R8 mosi bits", capWord,
        txo ? 32'h0 : (txw & maskOf(w)));
    chk(sclk == cpol, "R4 idle level", 32'(sclk), 32'(cpol));
    chk(irqSeen == 1 && irqBusy && irqEdges < 2 * w, "R10 irq before end", 32'(irqEdges), 32'(2 * w));
    expRx = loop ? (txo ? 32'h0 : (txw & maskOf(w))) : (slw & maskOf(w));
    if (rxo) begin
      chk(!rxValid, "R8 rx off stores nothing", 32'(rxValid), 32'h0);
    end else begin
      chk(rxValid && rxData == expRx, "R6/R7 rx word", rxData, expRx);
      rxRead = 1; @(negedge clk); rxRead = 0;
    end
    cfgEnable = 0;
  endtask

  initial begin
    #(5.0 * 150000);
    chk(0, "watchdog expired", 32'h0, 32'h1);
    finishRun();
  end

  initial begin
    int widths[6] = '{2, 3, 5, 8, 16, 32};
    int k = 0;
    repeat (4) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    // R12 reset state
    chk(!busy && !rxValid && !sclk, "R12 reset outputs", {29'h0, busy, rxValid, sclk}, 32'h0);
    chk(!txEmptyIrq && !txOverflow && !rxOverflow && !rxUnderflow, "R12 reset pulses",
        {28'h0, txEmptyIrq, txOverflow, rxOverflow, rxUnderflow}, 32'h0);

    // Sweep all clock modes, bit orders and several widths (R1..R7, R10)
    for (int pol = 0; pol < 2; pol++)
      for (int ph = 0; ph < 2; ph++)
        for (int mb = 0; mb < 2; mb++)
          for (int wi = 0; wi < 6; wi++) begin
            logic [31:0] tw, sw;
            tw = 32'h9E37_79B9 * (k + 1);
            sw = {tw[15:0], tw[31:16]} ^ 32'h5A5A_0F0F;
            runWord(widths[wi], pol[0], ph[0], mb[0], (k % 3), tw, sw, 0, 0, 0, 0);
            k++;
          end

    // R1 slower divider
    runWord(8, 0, 1, 1, 5, 32'h0000_00C5, 32'h0000_003A, 0, 0, 0, 0);
    // R6 loopback ignores miso
    runWord(8, 1, 0, 1, 1, 32'h0000_0096, 32'h0000_0069, 1, 0, 0, 0);
    runWord(16, 0, 1, 0, 0, 32'h0000_B00F, 32'h0000_FFFF, 1, 0, 0, 0);
    // R8 transmit off, receive still works
    runWord(8, 0, 1, 1, 0, 32'h0000_00FF, 32'h0000_0081, 0, 1, 0, 0);
    // R8 receive off
    runWord(8, 0, 0, 1, 0, 32'h0000_0055, 32'h0000_00AA, 0, 0, 1, 0);
    // R9 changes while active are ignored
    runWord(8, 0, 1, 1, 1, 32'h0000_00E1, 32'h0000_001E, 0, 0, 0, 1);

    // R4 idle level independent of polarity in config mode
    @(negedge clk); cfgEnable = 0; cfgPolarity = 0; cfgIdleHigh = 1;
    repeat (3) @(negedge clk);
    chk(sclk == 1'b1, "R4 idle high", 32'(sclk), 32'h1);
    cfgPolarity = 1; cfgIdleHigh = 0;
    repeat (3) @(negedge clk);
    chk(sclk == 1'b0, "R4 idle low", 32'(sclk), 32'h0);

    // R11 overflow and underflow
    cfgWidthM1 = 5'd1; cfgBaud = 0; cfgPolarity = 0; cfgIdleHigh = 0; cfgPhaseN = 1;
    cfgMsbFirst = 1; cfgLoopback = 1; cfgTxOff = 0; cfgRxOff = 0;
    txOvf = 0; rxOvf = 0; rxUnf = 0;
    repeat (2) @(negedge clk);
    for (int i = 0; i < 5; i++) begin
      txData = 32'(i); txWrite = 1; @(negedge clk);
    end
    txWrite = 0; @(negedge clk);
    chk(txOvf == 1, "R11 tx overflow pulse", 32'(txOvf), 32'h1);
    cfgEnable = 1;
    waitIdle();
    chk(rxOvf == 0, "R11 rx not yet overflowed", 32'(rxOvf), 32'h0);
    chk(rxValid && rxData == 32'h0, "R11 first kept word", rxData, 32'h0);
    txData = 32'h3; txWrite = 1; @(negedge clk); txWrite = 0;
    waitIdle();
    @(negedge clk);
    chk(rxOvf == 1, "R11 rx overflow pulse", 32'(rxOvf), 32'h1);
    for (int i = 0; i < 4; i++) begin
      chk(rxValid && rxData == 32'(i), "R11 queue order kept", rxData, 32'(i));
      rxRead = 1; @(negedge clk); rxRead = 0;
    end
    chk(!rxValid && rxUnf == 0, "R11 drained", 32'(rxUnf), 32'h0);
    rxRead = 1; @(negedge clk); rxRead = 0; @(negedge clk);
    chk(rxUnf == 1, "R11 rx underflow pulse", 32'(rxUnf), 32'h1);
    cfgEnable = 0;
    repeat (3) @(negedge clk);
    finishRun();
  end
endmodule